// File: doc/BRIEF.md
# PCIe Link-Up Monitor with Gen2 Stall Recovery

This block decides whether a PCIe link is really usable. Each check request makes it look at the PHY status: a link-up flag, an in-training flag, the 6-bit LTSSM state and the receiver rx_valid bit. A link that is up and no longer training is reported up at once. A link that is up but still training is looked at again after a fixed gap, for a bounded number of retries. A link that is down, or that never finishes training, goes to a stall test.

The stall test looks for a link that is stuck on its way to Gen2. The LTSSM sits in the receiver-lock state while the PHY reports no valid receive data. In that case the block drives two receiver override bits, data enable and PLL enable, high together for a fixed number of cycles, then drops them. Every check ends with a single-cycle done pulse. The verdict stays on `link_up` until the next check finishes.

States: `ST_IDLE` (wait for a request), `ST_EVAL` (sample the flags), `ST_GAP` (wait between retries), `ST_STALL` (run the stall test), `ST_RECOVER` (hold the overrides), `ST_DONE` (done pulse).

Transitions:
- `ST_IDLE`→`ST_EVAL` on a request.
- `ST_EVAL`→`ST_DONE` when the link is up and not training.
- `ST_EVAL`→`ST_STALL` when the link is down, or when the retries are used up.
- `ST_EVAL`→`ST_GAP` to retry.
- `ST_GAP`→`ST_EVAL` when the gap timer expires.
- `ST_STALL`→`ST_RECOVER` when the link is stuck.
- `ST_STALL`→`ST_DONE` otherwise.
- `ST_RECOVER`→`ST_DONE` when the hold timer expires.
- `ST_DONE`→`ST_IDLE` always.

Top module: `lnkmon_top`

## Requirements
- R1: After reset, `link_up`, `check_done`, `recovery_active` and both override outputs are 0.
- R2: A request is sampled on a clock edge, and the flags are sampled on the next edge. If at that edge `dbg_link_up`=1 and `dbg_in_training`=0, `check_done` pulses one cycle later with `link_up`=1. That is a latency of 1 cycle after the state that samples the flags.
- R3: If `dbg_link_up`=0 when sampled, no retry is made, whatever the training flag says. The check goes straight to the stall test and, with no stall, reports `link_up`=0 with a latency of 2.
- R4: While `dbg_link_up`=1 and `dbg_in_training`=1, the flags are sampled again every RETRY_GAP_CYC+1 cycles, up to RETRY_MAX more times. The link is reported up at the first sample that sees training clear, with latency n*(RETRY_GAP_CYC+1)+1 after n retries.
- R5: If training is still set at the last of the RETRY_MAX retries, the check goes to the stall test and reports `link_up`=0.
- R6: The link counts as stuck when `rx_valid`=0 and `ltssm_state`=6'h0D. A stuck link starts a recovery.
- R7: During a recovery, `ovrd_rx_data_en`, `ovrd_rx_pll_en` and `recovery_active` are high together for exactly HOLD_CYC cycles. Then they clear, and the check ends with `link_up`=0.
- R8: If `rx_valid`=1, or `ltssm_state` is not 6'h0D, the stall test makes no recovery and ends the check with a latency of 2 after a down sample.
- R9: `check_done` is a single-cycle pulse, one per accepted request. `link_up` keeps its value after the pulse.
- R10: A request that arrives while a check or a recovery is in progress has no effect. The hold length is unchanged and no extra done pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| check_req | input | 1 | Starts a link check, taken only when idle |
| dbg_link_up | input | 1 | PHY debug: link reported up |
| dbg_in_training | input | 1 | PHY debug: LTSSM still training |
| ltssm_state | input | 6 | PHY debug: current LTSSM state code |
| rx_valid | input | 1 | PHY receiver reports valid data |
| link_up | output | 1 | Verdict of the last completed check |
| check_done | output | 1 | One-cycle pulse at the end of a check |
| recovery_active | output | 1 | High while the receiver override pulse runs |
| ovrd_rx_data_en | output | 1 | Receiver data-enable override |
| ovrd_rx_pll_en | output | 1 | Receiver PLL-enable override |

## Verification
Some properties are checked on every cycle:
- An up verdict always rests on up-and-not-training flags from the cycle before.
- A recovery only starts from a stuck stall test.
- The override pulse never runs past HOLD_CYC cycles, and ends at exactly that length.
- The retry count stays bounded.
- A request seen during recovery cannot leave that path.
- The done pulse lasts one cycle.

Other properties only the scenarios can show, by matching each done pulse against a scoreboard entry:
- The exact latencies for each retry count.
- The correct verdict after training clears partway through the retries.
- The absence of a recovery when rx_valid is set or the state code differs.
- That an ignored request yields no extra done.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_EVAL    = 3'd1,
        ST_GAP     = 3'd2,
        ST_STALL   = 3'd3,
        ST_RECOVER = 3'd4,
        ST_DONE    = 3'd5
    } lnkmon_state_e;

    localparam int LTSSM_W = 6;
endpackage

// File: rtl/lnkmon_timer.sv
module lnkmon_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lnkmon_stall_detect.sv
module lnkmon_stall_detect
    import lnkmon_pkg::*;
#(
    parameter logic [LTSSM_W-1:0] STUCK_CODE = 6'h0D
) (
    input  logic [LTSSM_W-1:0] ltssm_state,
    input  logic               rx_valid,
    output logic               stuck
);
    assign stuck = !rx_valid && (ltssm_state == STUCK_CODE);
endmodule

// File: rtl/lnkmon_fsm.sv
module lnkmon_fsm
    import lnkmon_pkg::*;
#(
    parameter int RETRY_MAX     = 5,
    parameter int RETRY_GAP_CYC = 100000,
    parameter int HOLD_CYC      = 200000,
    parameter int CW            = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          check_req,
    input  logic          flag_up,
    input  logic          flag_train,
    input  logic          stuck,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          link_up,
    output logic          check_done,
    output logic          recovery_active,
    output logic          ovrd_data,
    output logic          ovrd_pll
);
    localparam int RW = $clog2(RETRY_MAX + 1);
    localparam int HW = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] GAP_LOAD  = CW'(RETRY_GAP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);
    localparam logic [RW-1:0] RETRY_LIM = RW'(RETRY_MAX);

    lnkmon_state_e state_q, state_d;
    logic [RW-1:0] retry_q;
    logic          verdict_q;

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (check_req) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (!flag_up) begin
                    state_d = ST_STALL;
                end else if (!flag_train) begin
                    state_d = ST_DONE;
                end else if (retry_q == RETRY_LIM) begin
                    state_d = ST_STALL;
                end else begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LOAD;
                end
            end
            ST_GAP: begin
                if (tmr_expired) state_d = ST_EVAL;
            end
            ST_STALL: begin
                if (stuck) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LOAD;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, retry count and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            retry_q   <= '0;
            verdict_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && check_req) begin
                retry_q <= '0;
            end else if (state_q == ST_EVAL && state_d == ST_GAP) begin
                retry_q <= retry_q + 1'b1;
            end
            if (state_q == ST_EVAL && state_d == ST_DONE) begin
                verdict_q <= 1'b1;
            end else if ((state_q == ST_STALL || state_q == ST_RECOVER)
                         && state_d == ST_DONE) begin
                verdict_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        link_up         = verdict_q;
        check_done      = (state_q == ST_DONE);
        recovery_active = (state_q == ST_RECOVER);
        ovrd_data       = (state_q == ST_RECOVER);
        ovrd_pll        = (state_q == ST_RECOVER);
    end

    // run length of the override pulse, used only by the checks below
    logic [HW-1:0] rec_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_run_q <= '0;
        else if (state_q == ST_RECOVER) rec_run_q <= rec_run_q + 1'b1;
        else rec_run_q <= '0;
    end

    a_r2_up_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done && link_up) |-> $past(flag_up && !flag_train));

    a_r4_retry_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RETRY_LIM);

    a_r6_recover_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recovery_active) |-> $past(stuck));

    a_r7_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rec_run_q <= HW'(HOLD_CYC));

    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovrd_data) |-> (rec_run_q == HW'(HOLD_CYC)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        check_done |=> !check_done);

    a_r10_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (recovery_active && check_req) |=> (recovery_active || check_done));
endmodule

// File: rtl/lnkmon_top.sv
module lnkmon_top
    import lnkmon_pkg::*;
#(
    parameter int RETRY_MAX     = 5,
    parameter int RETRY_GAP_CYC = 100000,
    parameter int HOLD_CYC      = 200000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check_req,
    input  logic               dbg_link_up,
    input  logic               dbg_in_training,
    input  logic [LTSSM_W-1:0] ltssm_state,
    input  logic               rx_valid,
    output logic               link_up,
    output logic               check_done,
    output logic               recovery_active,
    output logic               ovrd_rx_data_en,
    output logic               ovrd_rx_pll_en
);
    localparam int TMAX = (RETRY_GAP_CYC > HOLD_CYC) ? RETRY_GAP_CYC : HOLD_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    logic          stuck;
    logic          tmr_load;
    logic          tmr_expired;
    logic [CW-1:0] tmr_val;

    lnkmon_stall_detect u_stall (
        .ltssm_state (ltssm_state),
        .rx_valid    (rx_valid),
        .stuck       (stuck)
    );

    lnkmon_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lnkmon_fsm #(
        .RETRY_MAX     (RETRY_MAX),
        .RETRY_GAP_CYC (RETRY_GAP_CYC),
        .HOLD_CYC      (HOLD_CYC),
        .CW            (CW)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .check_req       (check_req),
        .flag_up         (dbg_link_up),
        .flag_train      (dbg_in_training),
        .stuck           (stuck),
        .tmr_expired     (tmr_expired),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .link_up         (link_up),
        .check_done      (check_done),
        .recovery_active (recovery_active),
        .ovrd_data       (ovrd_rx_data_en),
        .ovrd_pll        (ovrd_rx_pll_en)
    );
endmodule

// File: tb/tb_lnkmon_top.sv
module tb_lnkmon_top;
    localparam int CLK_PERIOD = 10;
    localparam int RMAX = 5;
    localparam int GAP  = 6;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       check_req = 1'b0;
    logic       dbg_link_up = 1'b0;
    logic       dbg_in_training = 1'b0;
    logic [5:0] ltssm_state = 6'h00;
    logic       rx_valid = 1'b0;
    logic       link_up, check_done, recovery_active, ovrd_rx_data_en, ovrd_rx_pll_en;

    lnkmon_top #(.RETRY_MAX(RMAX), .RETRY_GAP_CYC(GAP), .HOLD_CYC(HOLD)) dut (
        .clk (clk), .rst_n (rst_n), .check_req (check_req),
        .dbg_link_up (dbg_link_up), .dbg_in_training (dbg_in_training),
        .ltssm_state (ltssm_state), .rx_valid (rx_valid),
        .link_up (link_up), .check_done (check_done),
        .recovery_active (recovery_active),
        .ovrd_rx_data_en (ovrd_rx_data_en), .ovrd_rx_pll_en (ovrd_rx_pll_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    req_cyc;
        int    lat;
        int    rec;
        bit    up;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    int   rec_cnt = 0;
    bit   pair_bad = 1'b0;
    bit   post_pending = 1'b0;
    bit   last_up = 1'b0;
    string last_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compares each done pulse with the oldest scoreboard entry
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovrd_rx_data_en) rec_cnt++;
            if (ovrd_rx_data_en != ovrd_rx_pll_en || ovrd_rx_data_en != recovery_active)
                pair_bad = 1'b1;
            if (post_pending) begin
                post_pending = 1'b0;
                chk(!check_done, "R9", "done_width", int'(check_done), 0);
                chk(link_up == last_up, "R9", "link_up_held", int'(link_up), int'(last_up));
            end else if (check_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected_done", 1, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(link_up == it.up, it.tag, "link_up", int'(link_up), int'(it.up));
                    chk((cyc - it.req_cyc) == it.lat, it.tag, "latency",
                        cyc - it.req_cyc, it.lat);
                    chk(rec_cnt == it.rec, "R7", "override_cycles", rec_cnt, it.rec);
                    chk(!pair_bad, "R7", "override_pair", int'(pair_bad), 0);
                    last_up      = link_up;
                    last_tag     = it.tag;
                    post_pending = 1'b1;
                end
                rec_cnt  = 0;
                pair_bad = 1'b0;
            end
        end
    end

    // driver: sets inputs, pushes the expected result, pulses the request
    task automatic run_check(input bit up_f, input bit train_f, input logic [5:0] st,
                             input bit rxv, input int clear_after, input int extra_req_at,
                             input bit exp_up, input int exp_lat, input int exp_rec,
                             input string tag);
        exp_t it;
        int   c;
        @(negedge clk);
        dbg_link_up     = up_f;
        dbg_in_training = train_f;
        ltssm_state     = st;
        rx_valid        = rxv;
        check_req       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_req  = 1'b0;
        c          = cyc;
        it.req_cyc = c;
        it.lat     = exp_lat;
        it.rec     = exp_rec;
        it.up      = exp_up;
        it.tag     = tag;
        sb.push_back(it);
        if (clear_after > 0) begin
            while (cyc < c + clear_after * (GAP + 1) - 2) @(negedge clk);
            dbg_in_training = 1'b0;
        end
        if (extra_req_at > 0) begin
            while (cyc < c + extra_req_at) @(negedge clk);
            check_req = 1'b1;
            @(negedge clk);
            check_req = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(link_up == 1'b0, "R1", "link_up", int'(link_up), 0);
        chk(check_done == 1'b0, "R1", "check_done", int'(check_done), 0);
        chk(recovery_active == 1'b0, "R1", "recovery_active", int'(recovery_active), 0);
        chk(ovrd_rx_data_en == 1'b0 && ovrd_rx_pll_en == 1'b0, "R1", "overrides",
            int'(ovrd_rx_data_en) + int'(ovrd_rx_pll_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: up at once
        run_check(1, 0, 6'h11, 1, 0, 0, 1'b1, 1, 0, "R2");
        // R3: link down, no stall
        run_check(0, 0, 6'h11, 0, 0, 0, 1'b0, 2, 0, "R3");
        // R3: link down with training set, still no retry
        run_check(0, 1, 6'h05, 1, 0, 0, 1'b0, 2, 0, "R3");
        // R4: training clears before the third retry sample
        run_check(1, 1, 6'h11, 1, 3, 0, 1'b1, 3 * (GAP + 1) + 1, 0, "R4");
        // R5: retries used up, state not stuck
        run_check(1, 1, 6'h05, 0, 0, 0, 1'b0, RMAX * (GAP + 1) + 2, 0, "R5");
        // R5 + R7: retries used up, then stuck, recovery runs
        run_check(1, 1, 6'h0D, 0, 0, 0, 1'b0, RMAX * (GAP + 1) + 2 + HOLD, HOLD, "R5");
        // R6 + R7: link down and stuck
        run_check(0, 0, 6'h0D, 0, 0, 0, 1'b0, 2 + HOLD, HOLD, "R6");
        // R8: stuck state code but rx_valid set
        run_check(0, 0, 6'h0D, 1, 0, 0, 1'b0, 2, 0, "R8");
        // R8: rx_valid clear but a neighbouring state code
        run_check(0, 0, 6'h0C, 0, 0, 0, 1'b0, 2, 0, "R8");
        // R10: a second request mid-recovery changes nothing
        run_check(0, 0, 6'h0D, 0, 0, 10, 1'b0, 2 + HOLD, HOLD, "R10");
        // R9: verdict switches back to up on the next check
        run_check(1, 0, 6'h11, 1, 0, 0, 1'b1, 1, 0, "R9");

        repeat (30) @(negedge clk);
        chk(sb.size() == 0, "R10", "pending_entries", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule